// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Re-Assertion Hold-Off

This block merges interrupt requests from several on-chip producers into one host interrupt line. Three sources are latched locally: a timer event input, a software request raised by a register write, and a device-ready event input. Each is cleared by writing one to its status bit. The other sources are summary bits that follow the pending level of a sub-module. Software cannot clear these summary bits here. A summary bit falls only after the sub-module drops its own pending flag.

A configuration register holds four settings: a master enable, the line polarity, push-pull or open-drain drive, and a hold-off interval. Whenever the internal interrupt state changes from asserted to deasserted, a timer starts. The interval is counted in prescaled ticks of `PRESCALE` clock cycles each. While the timer runs, the line stays deasserted. The register port is a plain single-cycle write strobe with a combinational read mux. No stream data passes through this block, so it has no valid/ready handshake and no back-pressure.

Register map (address: contents):
- Address 0, status: bit 0 timer, bit 1 software, bit 2 ready, bits 3 and up cascaded.
- Address 1, enable: same bit layout as status.
- Address 2, configuration: bit 0 master enable, bit 1 polarity (1 = active-high), bit 2 open-drain, bit 3 read-only internal state, bits [4+DEAS_W-1:4] hold-off interval.
- Address 3, software trigger: write only, reads as zero.

Top module: `irq_hub`

## Requirements
- R1: A status bit can make the internal interrupt state assert only while its enable bit (address 1, same position) is set; the state follows the gated request one clock later.
- R2: Status bits 0 (evt_timer pulse), 1 (set by writing 1 to bit 0 of address 3) and 2 (evt_ready pulse) latch until a write to address 0 with a 1 in that position; writing 0 leaves them set, and an event in the same cycle as the clearing write keeps the bit set.
- R3: Status bit 3+k shows casc_pend[k] one clock later; writes to address 0 do not change it, and it drops only when casc_pend[k] drops.
- R4: With configuration bit 0 clear, the internal state stays deasserted whatever is pending.
- R5: Configuration bit 1 selects polarity: 1 drives irq_o high when asserted, 0 drives it low when asserted.
- R6: With configuration bit 2 clear, irq_oe is always 1. With it set, irq_oe is 1 only while asserted and 0 otherwise.
- R7: When the internal state falls, the next rise comes no sooner than D*PRESCALE+1 clock cycles later, where D is configuration bits [4+DEAS_W-1:4]. D = 0 leaves only the one-cycle gap.
- R8: The hold-off starts on every fall of the internal state, including a fall caused by clearing the master enable.
- R9: If the request is still pending when the hold-off ends, the state asserts in the first cycle after it ends.
- R10: Configuration bit 3 reads the internal interrupt state before polarity and drive mode are applied.
- R11: After reset all registers are zero: the state is deasserted, irq_o is 1 (active-low, deasserted) and irq_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr (combinational) |
| evt_timer | input | 1 | Timer event pulse |
| evt_ready | input | 1 | Device-ready event pulse |
| casc_pend | input | N_CASC | Pending levels of the cascaded sub-modules |
| irq_o | output | 1 | Interrupt pin drive value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
A vector table tries several combinations of enable mask, cascaded pending levels, polarity and drive mode. It separates four kinds of fault: a masked source that leaks through, an unmasked source that is missed, an inverted level, and a released line that is still driven. Directed sequences then pulse a cascaded source and toggle the master enable while a hold-off is set. They count the deasserted cycles exactly, which exposes a timer that is one tick short, one tick long, or ignores a cause of the fall. Latched bits are checked with zero writes, one writes and a clear that coincides with an event. This shows write-one-to-clear apart from plain write and confirms that the event wins.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_SWI  = 2'd3;

  localparam int N_DIRECT = 3;
  localparam int SRC_TMR  = 0;
  localparam int SRC_SW   = 1;
  localparam int SRC_RDY  = 2;

  localparam int CFG_MEN      = 0;
  localparam int CFG_POL      = 1;
  localparam int CFG_OD       = 2;
  localparam int CFG_STATE    = 3;
  localparam int CFG_DEAS_LSB = 4;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_hub_pkg::*;
#(
  parameter int N_CASC = 4,
  parameter int DEAS_W = 8,
  parameter int REG_W  = 12,
  localparam int SRC_W = N_DIRECT + N_CASC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              evt_timer,
  input  logic              evt_ready,
  input  logic [N_CASC-1:0] casc_pend,
  input  logic              irq_state,
  output logic [SRC_W-1:0]  stat_vec,
  output logic [SRC_W-1:0]  en_vec,
  output logic              pend_any,
  output logic              cfg_men,
  output logic              cfg_pol,
  output logic              cfg_od,
  output logic [DEAS_W-1:0] cfg_deas
);
  logic wr_stat, wr_en, wr_cfg, wr_swi;
  logic [N_DIRECT-1:0] dir_evt, dir_q;
  logic [N_CASC-1:0]   casc_q;

  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_en   = reg_wr && (reg_addr == ADDR_EN);
  assign wr_cfg  = reg_wr && (reg_addr == ADDR_CFG);
  assign wr_swi  = reg_wr && (reg_addr == ADDR_SWI);

  assign dir_evt[SRC_TMR] = evt_timer;
  assign dir_evt[SRC_SW]  = wr_swi && reg_wdata[0];
  assign dir_evt[SRC_RDY] = evt_ready;

  // latched sources: set wins over write-one-to-clear
  for (genvar g = 0; g < N_DIRECT; g++) begin : g_dir
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        bit_q <= 1'b0;
      else if (dir_evt[g])               bit_q <= 1'b1;
      else if (wr_stat && reg_wdata[g])  bit_q <= 1'b0;
    end
    assign dir_q[g] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      casc_q   <= '0;
      en_vec   <= '0;
      cfg_men  <= 1'b0;
      cfg_pol  <= 1'b0;
      cfg_od   <= 1'b0;
      cfg_deas <= '0;
    end else begin
      casc_q <= casc_pend;
      if (wr_en) en_vec <= reg_wdata[SRC_W-1:0];
      if (wr_cfg) begin
        cfg_men  <= reg_wdata[CFG_MEN];
        cfg_pol  <= reg_wdata[CFG_POL];
        cfg_od   <= reg_wdata[CFG_OD];
        cfg_deas <= reg_wdata[CFG_DEAS_LSB +: DEAS_W];
      end
    end
  end

  assign stat_vec = {casc_q, dir_q};
  assign pend_any = cfg_men && (|(stat_vec & en_vec));

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_STAT: reg_rdata[SRC_W-1:0] = stat_vec;
      ADDR_EN:   reg_rdata[SRC_W-1:0] = en_vec;
      ADDR_CFG: begin
        reg_rdata[CFG_MEN]   = cfg_men;
        reg_rdata[CFG_POL]   = cfg_pol;
        reg_rdata[CFG_OD]    = cfg_od;
        reg_rdata[CFG_STATE] = irq_state;
        reg_rdata[CFG_DEAS_LSB +: DEAS_W] = cfg_deas;
      end
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_deas_timer.sv
module irq_deas_timer #(
  parameter int DEAS_W   = 8,
  parameter int PRESCALE = 4,
  localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DEAS_W-1:0] interval,
  output logic              busy
);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [DEAS_W-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (load) begin
      pre_q  <= PRE_TOP;
      tick_q <= interval;
    end else if (tick_q != '0) begin
      if (pre_q == '0) begin
        pre_q  <= PRE_TOP;
        tick_q <= tick_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign busy = (tick_q != '0);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic irq_state,
  input  logic cfg_pol,
  input  logic cfg_od,
  output logic irq_o,
  output logic irq_oe
);
  assign irq_o  = cfg_pol ? irq_state : ~irq_state;
  assign irq_oe = cfg_od ? irq_state : 1'b1;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_CASC   = 4,
  parameter int DEAS_W   = 8,
  parameter int PRESCALE = 4,
  localparam int SRC_W   = N_DIRECT + N_CASC,
  localparam int REG_W   = (SRC_W > CFG_DEAS_LSB + DEAS_W) ? SRC_W : CFG_DEAS_LSB + DEAS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              evt_timer,
  input  logic              evt_ready,
  input  logic [N_CASC-1:0] casc_pend,
  output logic              irq_o,
  output logic              irq_oe
);
  logic [SRC_W-1:0]  stat_vec, en_vec;
  logic              pend_any, cfg_men, cfg_pol, cfg_od;
  logic [DEAS_W-1:0] cfg_deas;
  logic              irq_state, busy, fall;

  irq_src_regs #(.N_CASC(N_CASC), .DEAS_W(DEAS_W), .REG_W(REG_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .evt_timer, .evt_ready, .casc_pend, .irq_state,
    .stat_vec, .en_vec, .pend_any, .cfg_men, .cfg_pol, .cfg_od, .cfg_deas
  );

  // fall of the asserted state, for any reason, arms the hold-off
  assign fall = irq_state && !pend_any;

  irq_deas_timer #(.DEAS_W(DEAS_W), .PRESCALE(PRESCALE)) u_timer (
    .clk, .rst_n, .load(fall), .interval(cfg_deas), .busy
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_state <= 1'b0;
    else        irq_state <= pend_any && !busy;
  end

  irq_pin_drv u_pin (
    .irq_state, .cfg_pol, .cfg_od, .irq_o, .irq_oe
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_CASC = 4,
  parameter int DEAS_W = 8,
  localparam int SRC_W = 3 + N_CASC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic              wdata_b0,
  input logic [N_CASC-1:0] casc_pend,
  input logic [SRC_W-1:0]  stat_vec,
  input logic [SRC_W-1:0]  en_vec,
  input logic              cfg_men,
  input logic              cfg_od,
  input logic [DEAS_W-1:0] cfg_deas,
  input logic              irq_state,
  input logic              busy,
  input logic              irq_oe
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_vec & en_vec)) |=> !irq_state); // R1
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !wdata_b0 && stat_vec[0]) |=> stat_vec[0]); // R2
  AST_CASC_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (stat_vec[SRC_W-1:3] == $past(casc_pend))); // R3
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_men |=> !irq_state); // R4
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_od && !irq_state) |-> !irq_oe); // R6
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !irq_state); // R7
  AST_FALL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(irq_state) && cfg_deas != '0) |-> busy); // R8
endmodule

bind irq_hub irq_hub_chk #(.N_CASC(N_CASC), .DEAS_W(DEAS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wdata_b0(reg_wdata[0]), .casc_pend(casc_pend), .stat_vec(stat_vec),
  .en_vec(en_vec), .cfg_men(cfg_men), .cfg_od(cfg_od), .cfg_deas(cfg_deas),
  .irq_state(irq_state), .busy(busy), .irq_oe(irq_oe)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int REG_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic evt_timer = 1'b0, evt_ready = 1'b0;
  logic [3:0] casc_pend = 4'd0;
  logic irq_o, irq_oe;

  int nchk = 0, nfail = 0, lows = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_hub u_irq_hub (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .evt_timer, .evt_ready, .casc_pend, .irq_o, .irq_oe
  );

  typedef struct packed {
    logic [6:0] en;
    logic [3:0] casc;
    logic       pol;
    logic       od;
    logic       exp_o;
    logic       exp_oe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{7'b0001000, 4'b0001, 1'b1, 1'b0, 1'b1, 1'b1},
    '{7'b0001000, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b1},
    '{7'b0010000, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b1},
    '{7'b0010000, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b1},
    '{7'b0010000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0},
    '{7'b1111000, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b1},
    '{7'b0000000, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1},
    '{7'b1000000, 4'b0111, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  function automatic logic [REG_W-1:0] cfgw(logic men, logic pol, logic od, logic [7:0] d);
    return {d, 1'b0, od, pol, men};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [REG_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [REG_W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_count();
    @(negedge clk);
    #1 if (!irq_o) lows++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [REG_W-1:0] d;
    idle(3);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 irq_o", irq_o, 1);
    check("R11 irq_oe", irq_oe, 1);
    rd(2'd0, d); check("R11 status", d, 0);
    rd(2'd2, d); check("R11 config", d, 0);

    // table walk: R1 R3 R5 R6
    foreach (VECS[i]) begin
      wr(2'd1, REG_W'(VECS[i].en));
      wr(2'd2, cfgw(1'b1, VECS[i].pol, VECS[i].od, 8'd0));
      casc_pend = VECS[i].casc;
      idle(3);
      #1;
      check($sformatf("R1/R5 vec%0d irq_o", i), irq_o, VECS[i].exp_o);
      check($sformatf("R6 vec%0d irq_oe", i), irq_oe, VECS[i].exp_oe);
    end
    casc_pend = 4'd0;
    wr(2'd1, '0);
    idle(2);

    // R2 latched bits
    @(negedge clk); evt_timer = 1'b1; @(negedge clk); evt_timer = 1'b0;
    rd(2'd0, d); check("R2 timer latched", d[0], 1);
    wr(2'd0, 12'h000);
    rd(2'd0, d); check("R2 zero write keeps", d[0], 1);
    wr(2'd0, 12'h001);
    rd(2'd0, d); check("R2 w1c clears", d[0], 0);
    wr(2'd3, 12'h001);
    rd(2'd0, d); check("R2 software set", d[2:0], 3'b010);
    @(negedge clk);
    evt_ready = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 12'h006;
    @(negedge clk);
    evt_ready = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, d); check("R2 event beats clear", d[2:0], 3'b100);
    wr(2'd0, 12'h004);
    rd(2'd0, d); check("R2 ready cleared", d[2:0], 3'b000);

    // R3 cascaded summary not clearable
    casc_pend = 4'b0001; idle(2);
    wr(2'd0, 12'h078);
    rd(2'd0, d); check("R3 write ignored", d[6:3], 4'b0001);
    casc_pend = 4'b0000; idle(2);
    rd(2'd0, d); check("R3 follows source", d[6:3], 4'b0000);

    // R4 / R10 master enable and state readback
    wr(2'd1, 12'h001);
    @(negedge clk); evt_timer = 1'b1; @(negedge clk); evt_timer = 1'b0;
    wr(2'd2, cfgw(1'b0, 1'b1, 1'b0, 8'd0));
    idle(2);
    rd(2'd2, d); check("R4 master off state", d[3], 0);
    #0 check("R4 master off pin", irq_o, 0);
    wr(2'd2, cfgw(1'b1, 1'b1, 1'b0, 8'd0));
    idle(2);
    rd(2'd2, d); check("R10 state bit", d[3], 1);
    wr(2'd2, cfgw(1'b1, 1'b0, 1'b1, 8'd0));
    idle(1);
    rd(2'd2, d); check("R10 state before polarity", d[3], 1);
    wr(2'd0, 12'h001);
    wr(2'd1, 12'h008);

    // R7 R9 hold-off of 3 ticks x 4 cycles, refired at once
    wr(2'd2, cfgw(1'b1, 1'b1, 1'b0, 8'd3));
    casc_pend = 4'b0001; idle(4);
    lows = 0;
    casc_pend = 4'b0000;
    tick_count();
    casc_pend = 4'b0001;
    for (int i = 0; i < 30; i++) tick_count();
    check("R7/R9 low cycles D=3", lows, 13);

    // R7 zero interval
    wr(2'd2, cfgw(1'b1, 1'b1, 1'b0, 8'd0));
    idle(3);
    lows = 0;
    casc_pend = 4'b0000;
    tick_count();
    casc_pend = 4'b0001;
    for (int i = 0; i < 10; i++) tick_count();
    check("R7 low cycles D=0", lows, 1);

    // R8 master disable starts hold-off, D=2
    wr(2'd2, cfgw(1'b1, 1'b1, 1'b0, 8'd2));
    idle(3);
    lows = 0;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = cfgw(1'b0, 1'b1, 1'b0, 8'd2);
    #1 if (!irq_o) lows++;
    @(negedge clk);
    reg_wdata = cfgw(1'b1, 1'b1, 1'b0, 8'd2);
    #1 if (!irq_o) lows++;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    #1 if (!irq_o) lows++;
    for (int i = 0; i < 20; i++) tick_count();
    check("R8 low cycles after master toggle", lows, 9);
    check("R9 reasserted", irq_o, 1);

    finish_run();
  end
endmodule